// File: doc/BRIEF.md
# I2C Serial Clock Generator

This block turns the system clock into the serial clock of an I2C master. A prescaler divides the system clock down to a module tick, and two count settings set how many ticks the line is held low and how many it stays released high. Each phase also carries a fixed overhead of 5, 6 or 7 ticks, picked by the prescaler setting. A period therefore takes (prescaler + 1) × (low + high + 2 × overhead) system clocks, plus the time the line needs to be seen high again.

The three settings are captured while the block is disabled and stay frozen while it is enabled. The master's bit engine asserts a run request to start clocking, and each period begins with the low phase. The block pulls the line low through an open-drain enable and watches the line through a synchronizer. The high phase count starts only once the line is seen high, so a target that holds SCL low stretches the clock. Two one-cycle strobes go to the bit engine. The first marks the middle of the low phase, where data may change. The second marks the cycle in which the rising edge is recognised, where data is sampled.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rst_n` or `mod_en` is low, `scl_drive_low`, `data_chg_stb` and `sample_stb` are 0; dropping `mod_en` releases the line from the next cycle on.
- R2: `psc_cfg`, `low_cfg` and `high_cfg` are captured on every cycle in which `mod_en` is low; changes made while `mod_en` is high have no effect on the phase lengths.
- R3: With `mod_en` high, an idle block that samples `run_req` high drives the line low from the next cycle; every period starts with the low phase.
- R4: The per-phase overhead d is 7 when the captured prescaler is 0, 6 when it is 1, and 5 when it is 2 or larger.
- R5: The low phase lasts (psc + 1) × (low + d) system clocks.
- R6: `data_chg_stb` pulses exactly once per low phase, in the cycle at offset (psc + 1) × floor((low + d) / 2) + psc counted from the first low cycle (offset 0).
- R7: After release, `sample_stb` pulses once, in the first cycle in which `scl_in` is seen high after SYNC_STAGES synchronizer flops. If the line is held low for S cycles after release, this is release cycle S + SYNC_STAGES.
- R8: After the `sample_stb` cycle, the line stays released for (psc + 1) × (high + d) system clocks before the next low phase.
- R9: At the end of a high phase, the next low phase starts at once if `run_req` is high. Otherwise the block goes idle with the line released and both strobes quiet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mod_en | input | 1 | Module enable; low holds the block idle and opens the settings |
| run_req | input | 1 | Run request from the bit engine |
| psc_cfg | input | PSC_W | Prescaler setting; tick = clk / (psc_cfg + 1) |
| low_cfg | input | CNT_W | Low phase count setting |
| high_cfg | input | CNT_W | High phase count setting |
| scl_in | input | 1 | Sensed level of the SCL line |
| scl_drive_low | output | 1 | Open-drain enable; 1 pulls SCL low |
| data_chg_stb | output | 1 | One-cycle strobe in the middle of the low phase |
| sample_stb | output | 1 | One-cycle strobe when the rising edge is recognised |

## Verification
A wrong prescaler or phase counter shows up in the first low phase after start. It moves the data-change strobe and ends the low phase at a cycle other than the one the formula predicts. A wrong synchronizer or stretch state shows up in the same period as a misplaced or missing sampling strobe. A run-request or enable decision taken in the wrong state shows up as a low phase that starts or persists when it should not, within one cycle of the end of a high phase or of the enable drop.

// File: rtl/scl_pkg.sv
// Shared types and helpers of the serial clock generator.
// Assumes the prescaler value is passed zero-extended to 32 bits.
package scl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    // Fixed per-phase overhead in ticks, chosen by the prescaler setting.
    function automatic logic [3:0] phase_offset(input logic [31:0] div_sel);
        if (div_sel == 32'd0)
            return 4'd7;
        else if (div_sel == 32'd1)
            return 4'd6;
        else
            return 4'd5;
    endfunction

endpackage

// File: rtl/scl_tick_div.sv
// Prescaler: pulses tick once every (div_max + 1) cycles while count_en is high.
// Assumes count_en low restarts the division so each phase begins aligned.
module scl_tick_div #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             count_en,
    input  logic [PSC_W-1:0] div_max,
    output logic             tick
);

    logic [PSC_W-1:0] div_cnt;

    // Count system clocks within one tick, wrapping at div_max.
    always_ff @(posedge clk) begin
        if (!rst_n || !count_en)
            div_cnt <= '0;
        else if (div_cnt == div_max)
            div_cnt <= '0;
        else
            div_cnt <= div_cnt + PSC_W'(1);
    end

    assign tick = count_en && (div_cnt == div_max);

endmodule

// File: rtl/scl_line_sync.sv
// Synchronizer for the sensed SCL level, STAGES flops deep.
// Assumes the line reads high (released) out of reset.
module scl_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_out
);

    logic [STAGES-1:0] sync_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // First flop samples the asynchronous line.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= line_in;
            end
        end else begin : g_next
            // Later flops pass the level along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b1;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign line_out = sync_q[STAGES-1];

endmodule

// File: rtl/scl_phase_ctrl.sv
// Phase sequencer: idle, low, wait-for-high (stretch), high.
// Counts ticks per phase and raises the two bit-engine strobes.
// Assumes low_len and high_len already include the overhead and are >= 2.
module scl_phase_ctrl #(
    parameter int LEN_W = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             run_req,
    input  logic             tick,
    input  logic [LEN_W-1:0] low_len,
    input  logic [LEN_W-1:0] high_len,
    input  logic             line_high,
    output logic             count_en,
    output logic             drive_low,
    output logic             mid_stb,
    output logic             rise_stb
);
    import scl_pkg::*;

    scl_phase_e       state;
    logic [LEN_W-1:0] ph_cnt;
    logic             low_done;
    logic             high_done;

    assign low_done  = tick && (ph_cnt == low_len - LEN_W'(1));
    assign high_done = tick && (ph_cnt == high_len - LEN_W'(1));

    // Advance the phase state and the tick count within the phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            state  <= PH_IDLE;
            ph_cnt <= '0;
        end else begin
            unique case (state)
                PH_IDLE: begin
                    ph_cnt <= '0;
                    if (run_req) state <= PH_LOW;
                end
                PH_LOW: begin
                    if (low_done) begin
                        state  <= PH_WAIT;
                        ph_cnt <= '0;
                    end else if (tick) begin
                        ph_cnt <= ph_cnt + LEN_W'(1);
                    end
                end
                PH_WAIT: begin
                    ph_cnt <= '0;
                    if (line_high) state <= PH_HIGH;
                end
                PH_HIGH: begin
                    if (high_done) begin
                        state  <= run_req ? PH_LOW : PH_IDLE;
                        ph_cnt <= '0;
                    end else if (tick) begin
                        ph_cnt <= ph_cnt + LEN_W'(1);
                    end
                end
                default: begin
                    state  <= PH_IDLE;
                    ph_cnt <= '0;
                end
            endcase
        end
    end

    assign count_en  = (state == PH_LOW) || (state == PH_HIGH);
    assign drive_low = (state == PH_LOW);
    assign mid_stb   = (state == PH_LOW) && tick && (ph_cnt == (low_len >> 1));
    assign rise_stb  = (state == PH_WAIT) && line_high;

endmodule

// File: rtl/i2c_scl_gen.sv
// Top of the serial clock generator. Captures the settings while
// disabled, derives the phase lengths with the overhead, and ties the
// prescaler, line synchronizer and phase sequencer together.
// Assumes scl_in is the wired line level (may be asynchronous).
module i2c_scl_gen #(
    parameter int PSC_W       = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_en,
    input  logic             run_req,
    input  logic [PSC_W-1:0] psc_cfg,
    input  logic [CNT_W-1:0] low_cfg,
    input  logic [CNT_W-1:0] high_cfg,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             data_chg_stb,
    output logic             sample_stb
);
    import scl_pkg::*;

    localparam int LEN_W = CNT_W + 1;

    logic [PSC_W-1:0] cfg_psc;
    logic [CNT_W-1:0] cfg_low;
    logic [CNT_W-1:0] cfg_high;
    logic [3:0]       ovh;
    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             count_en;
    logic             tick;
    logic             line_high;

    // Capture the settings only while the block is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_psc  <= '0;
            cfg_low  <= '0;
            cfg_high <= '0;
        end else if (!mod_en) begin
            cfg_psc  <= psc_cfg;
            cfg_low  <= low_cfg;
            cfg_high <= high_cfg;
        end
    end

    assign ovh      = phase_offset(32'(cfg_psc));
    assign low_len  = LEN_W'(cfg_low) + LEN_W'(ovh);
    assign high_len = LEN_W'(cfg_high) + LEN_W'(ovh);

    scl_tick_div #(.PSC_W(PSC_W)) i_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (count_en),
        .div_max  (cfg_psc),
        .tick     (tick)
    );

    scl_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .line_in  (scl_in),
        .line_out (line_high)
    );

    scl_phase_ctrl #(.LEN_W(LEN_W)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (mod_en),
        .run_req   (run_req),
        .tick      (tick),
        .low_len   (low_len),
        .high_len  (high_len),
        .line_high (line_high),
        .count_en  (count_en),
        .drive_low (scl_drive_low),
        .mid_stb   (data_chg_stb),
        .rise_stb  (sample_stb)
    );

endmodule

// File: rtl/scl_gen_checker.sv
// Protocol checks for the serial clock generator, bound to its top.
module scl_gen_checker #(
    parameter int PSC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mod_en,
    input logic             run_req,
    input logic             scl_drive_low,
    input logic             data_chg_stb,
    input logic             sample_stb,
    input logic [PSC_W-1:0] cfg_psc
);

    p_disable_release_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_en |=> (!scl_drive_low && !data_chg_stb && !sample_stb));

    p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_en && $past(mod_en)) |-> $stable(cfg_psc));

    p_low_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_drive_low) |-> ($past(run_req) && $past(mod_en)));

    p_mid_inside_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        data_chg_stb |-> scl_drive_low);

    p_sample_released_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> !scl_drive_low);

    p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({data_chg_stb, sample_stb}));

endmodule

bind i2c_scl_gen scl_gen_checker #(.PSC_W(PSC_W)) i_scl_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .mod_en        (mod_en),
    .run_req       (run_req),
    .scl_drive_low (scl_drive_low),
    .data_chg_stb  (data_chg_stb),
    .sample_stb    (sample_stb),
    .cfg_psc       (cfg_psc)
);

// File: tb/test_i2c_scl_gen.sv
// Bench for the serial clock generator: loops SCL back with an optional
// stretch hold and measures every phase against computed lengths.
module test_i2c_scl_gen;

    localparam int PSC_W = 8;
    localparam int CNT_W = 16;
    localparam int SYNC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mod_en = 1'b0;
    logic             run_req = 1'b0;
    logic [PSC_W-1:0] psc_cfg = '0;
    logic [CNT_W-1:0] low_cfg = '0;
    logic [CNT_W-1:0] high_cfg = '0;
    logic             hold = 1'b0;
    logic             scl_in;
    logic             scl_drive_low;
    logic             data_chg_stb;
    logic             sample_stb;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    assign scl_in = !scl_drive_low && !hold;

    always #4 clk = ~clk;

    i2c_scl_gen #(.PSC_W(PSC_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC)) i_i2c_scl_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .mod_en        (mod_en),
        .run_req       (run_req),
        .psc_cfg       (psc_cfg),
        .low_cfg       (low_cfg),
        .high_cfg      (high_cfg),
        .scl_in        (scl_in),
        .scl_drive_low (scl_drive_low),
        .data_chg_stb  (data_chg_stb),
        .sample_stb    (sample_stb)
    );

    function automatic int ovh_of(input int p);
        return (p == 0) ? 7 : (p == 1) ? 6 : 5;
    endfunction

    function automatic int phase_clocks(input int p, input int cnt);
        return (p + 1) * (cnt + ovh_of(p));
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Count low cycles from the current negedge; note the data-change strobe.
    task automatic measure_low(output int len, output int mid_idx, output int mid_n);
        len = 0; mid_idx = -1; mid_n = 0;
        while (scl_drive_low && len < 100000) begin
            if (data_chg_stb) begin mid_n++; mid_idx = len; end
            len++;
            @(negedge clk);
        end
    endtask

    // Count released cycles, holding the line low for s cycles (stretch).
    task automatic measure_rel(input int s, input bit drop, input int limit,
                               output int len, output int rise_idx, output int rise_n);
        len = 0; rise_idx = -1; rise_n = 0;
        while (!scl_drive_low && len < limit) begin
            if (sample_stb) begin
                rise_n++; rise_idx = len;
                if (drop) run_req = 1'b0;
            end
            if (len == s) hold = 1'b0;
            else if (len == 0) hold = 1'b1;
            len++;
            @(negedge clk);
        end
        hold = 1'b0;
    endtask

    task automatic run_case(input int p, input int lo, input int hi, input int s, input int nper);
        int len, idx, n, exp_rel;
        mod_en = 1'b0;
        psc_cfg = PSC_W'(p); low_cfg = CNT_W'(lo); high_cfg = CNT_W'(hi);
        tick_n(2);
        mod_en = 1'b1;
        // R2: settings moved after enable must not matter
        psc_cfg = PSC_W'($urandom); low_cfg = CNT_W'($urandom % 50); high_cfg = CNT_W'($urandom % 50);
        tick_n(1);
        run_req = 1'b1;
        tick_n(1);
        chk("R3 low starts one cycle after run", int'(scl_drive_low), 1);
        exp_rel = s + SYNC + 1 + phase_clocks(p, hi);
        for (int per = 0; per < nper; per++) begin
            measure_low(len, idx, n);
            chk("R5 low length (R4 overhead)", len, phase_clocks(p, lo));
            chk("R6 data-change strobe offset", idx, (p + 1) * ((lo + ovh_of(p)) / 2) + p);
            chk("R6 data-change strobe count", n, 1);
            if (per < nper - 1) begin
                measure_rel(s, 1'b0, exp_rel + 50, len, idx, n);
                chk("R7 sample strobe offset", idx, s + SYNC);
                chk("R8 released length", len, exp_rel);
            end else begin
                measure_rel(s, 1'b1, exp_rel + 20, len, idx, n);
                chk("R7 sample strobe count", n, 1);
                chk("R9 idle after run dropped", len, exp_rel + 20);
                chk("R9 no strobe while idle", int'(data_chg_stb || sample_stb), 0);
            end
        end
        mod_en = 1'b0;
        run_req = 1'b0;
        tick_n(2);
    endtask

    initial begin
        int len, idx, n;
        void'($urandom(32'd20240611));
        tick_n(3);
        chk("R1 reset: line released", int'(scl_drive_low), 0);
        chk("R1 reset: strobes quiet", int'(data_chg_stb || sample_stb), 0);
        rst_n = 1'b1;

        // R1: run while disabled does nothing
        run_req = 1'b1;
        tick_n(20);
        chk("R1 disabled ignores run", int'(scl_drive_low), 0);
        run_req = 1'b0;

        // R2: enable with short settings, then write large ones
        psc_cfg = 8'd0; low_cfg = 16'd3; high_cfg = 16'd1;
        tick_n(2);
        mod_en = 1'b1;
        psc_cfg = 8'd9; low_cfg = 16'd40; high_cfg = 16'd40;
        tick_n(1);
        run_req = 1'b1;
        tick_n(1);
        measure_low(len, idx, n);
        chk("R2 late settings ignored (low length)", len, 10);

        // R1: dropping enable mid-low releases on the next cycle
        tick_n(30);
        while (!scl_drive_low) @(negedge clk);
        tick_n(2);
        mod_en = 1'b0;
        tick_n(1);
        chk("R1 release after enable drop", int'(scl_drive_low), 0);
        run_req = 1'b0;
        tick_n(2);

        // Directed corners: each overhead value, large prescaler, stretch
        run_case(0, 0, 0, 0, 2);
        run_case(1, 0, 0, 0, 2);
        run_case(2, 0, 0, 1, 2);
        run_case(3, 5, 2, 3, 2);
        run_case(255, 0, 1, 0, 2);
        run_case(0, 12, 9, 6, 3);

        for (int k = 0; k < 24; k++)
            run_case(int'($urandom % 6), int'($urandom % 13), int'($urandom % 13),
                     int'($urandom % 5), 2 + int'($urandom % 2));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule